// File: doc/BRIEF.md
# Address Line 20 Gate Controller

This block decides whether address line 20 of a PC-compatible memory bus is passed through or forced low. Two independent paths, both reached over a small 8-bit I/O bus, can open the gate. The first behaves like a legacy keyboard controller. A command byte of 0xD1 is written to its command port, and the next byte written to its data port is loaded into an 8-bit output register. Bit 1 of that register opens the gate. The controller shows a busy flag in its status register after every accepted write. The second path is a fast system-control port whose bit 1 opens the gate on its own.

The effective gate is the OR of the two enable bits. A masking stage clears bit 20 of every memory address that passes through while the gate is closed. This makes an access to 0x100000 alias to 0. Either path can also request a processor reset: writing bit 0 of the output register as 0, or writing bit 0 of the fast port as 1, produces a one-cycle reset request. The other six output register bits are plain storage and appear on a pin bus.

Top module: `a20_gate_ctrl`

## Requirements
- R1: After reset the output register reads 0x01, the fast enable is 0, the gate is closed, the busy flag is 0 and no reset request is active.
- R2: After each accepted write to the command port (0x64) or data port (0x60), status bit 1 (busy) reads 1 for exactly BUSY_CYCLES cycles and then reads 0. The other status bits read 0.
- R3: A command or data write made while busy is 1 is dropped. It changes neither the output register nor the pending-command state.
- R4: An accepted 0xD1 command followed by an accepted data write loads the data byte into the output register. The register reads back at the data port and drives the outport pins. The gate follows bit 1 one cycle after the write.
- R5: A data write with no pending 0xD1 leaves the output register unchanged. A data write that loads the register consumes the pending command, so a second data write is ignored.
- R6: An accepted command byte other than 0xD1 cancels a pending 0xD1.
- R7: A write to the fast port (0x92) stores bit 1 as the fast enable. A read of that port returns it in bit 1, with all other bits 0.
- R8: The gate output is 1 whenever either the output-register bit 1 or the fast enable is 1.
- R9: Loading the output register with bit 0 at 0, or writing the fast port with bit 0 at 1, raises cpu_reset_req for exactly one cycle, starting the cycle after the write.
- R10: While the gate is closed mem_addr_out equals mem_addr_in with bit 20 cleared. While it is open, mem_addr_out equals mem_addr_in.
- R11: Reads of any unmapped port, and any output when io_rd is 0, return 0 on io_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| mem_addr_in | input | 32 | Memory address from the processor |
| mem_addr_out | output | 32 | Memory address after gating |
| a20_en | output | 1 | Effective gate state |
| cpu_reset_req | output | 1 | One-cycle processor reset request |
| outport | output | 8 | Output register contents |

## Verification
The command path is exercised with several orderings. A proper 0xD1 plus parameter sequence shows that loading works at all. A parameter written while busy shows that the busy flag really blocks writes. A stray parameter, a repeated parameter and an intervening other command each show that only the byte immediately following 0xD1 lands. The fast port is tried with the keyboard bit both open and closed, which separates the OR of the two enables from either one alone. Reset requests are sampled on the cycle after the write and the cycle after that, which distinguishes a pulse from a level. Addresses with and without bit 20 set are compared against the gate state.

// File: rtl/a20_pkg.sv
package a20_pkg;
  localparam logic [7:0] CMD_LOAD_OUTREG = 8'hD1;
  localparam logic [7:0] OUTREG_INIT     = 8'h01;
  localparam int OUT_RSTN_BIT  = 0;
  localparam int OUT_GATE_BIT  = 1;
  localparam int STAT_BUSY_BIT = 1;
  localparam int FAST_RST_BIT  = 0;
  localparam int FAST_GATE_BIT = 1;
  localparam int GATED_ADDR_BIT = 20;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_FAST = 2'd3
  } port_sel_e;
endpackage

// File: rtl/a20_kbc.sv
module a20_kbc
  import a20_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  output logic       busy,
  output logic [7:0] outreg,
  output logic       rst_pulse
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busy_cnt;
  logic             pend_q;
  logic             cmd_take;
  logic             data_take;
  logic             load_evt;

  assign busy      = (busy_cnt != '0);
  assign cmd_take  = cmd_wr && !busy;
  assign data_take = data_wr && !busy;
  assign load_evt  = data_take && pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (cmd_take || data_take) begin
      busy_cnt <= CNT_W'(BUSY_CYCLES);
    end else if (busy) begin
      busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (cmd_take) begin
      pend_q <= (wdata == CMD_LOAD_OUTREG);
    end else if (data_take) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outreg    <= OUTREG_INIT;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= load_evt && !wdata[OUT_RSTN_BIT];
      if (load_evt) outreg <= wdata;
    end
  end

  assert_busy_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take || data_take) |=> busy);
  assert_drop_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_wr || data_wr) && busy) |=> ($stable(outreg) && $stable(pend_q)));
  assert_load_needs_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(outreg) |-> $past(pend_q));
  assert_other_cmd_cancels_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_take && wdata != CMD_LOAD_OUTREG) |=> !pend_q);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse);
endmodule

// File: rtl/a20_fastport.sv
module a20_fastport
  import a20_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [1:0] wbits,
  output logic       gate,
  output logic       rst_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate      <= 1'b0;
      rst_pulse <= 1'b0;
    end else begin
      rst_pulse <= wr && wbits[FAST_RST_BIT];
      if (wr) gate <= wbits[FAST_GATE_BIT];
    end
  end

  assert_fast_gate_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate) |-> $past(wr));
endmodule

// File: rtl/a20_addr_mask.sv
module a20_addr_mask
  import a20_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  function automatic logic [ADDR_W-1:0] gate_addr(input logic [ADDR_W-1:0] a,
                                                  input logic en);
    logic [ADDR_W-1:0] r;
    r = a;
    if (!en) r[GATED_ADDR_BIT] = 1'b0;
    return r;
  endfunction

  assign addr_out = gate_addr(addr_in, open);

  assert_closed_bit_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !open |-> (addr_out[GATED_ADDR_BIT] == 1'b0));
  assert_open_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    open |-> (addr_out == addr_in));
endmodule

// File: rtl/a20_gate_ctrl.sv
module a20_gate_ctrl
  import a20_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          IO_AW       = 16,
  parameter int          BUSY_CYCLES = 4,
  parameter logic [15:0] CMD_PORT    = 16'h0064,
  parameter logic [15:0] DATA_PORT   = 16'h0060,
  parameter logic [15:0] FAST_PORT   = 16'h0092
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic [ADDR_W-1:0] mem_addr_in,
  output logic [ADDR_W-1:0] mem_addr_out,
  output logic              a20_en,
  output logic              cpu_reset_req,
  output logic [7:0]        outport
);
  port_sel_e sel;
  logic      kbc_busy;
  logic      kbc_rst;
  logic      fast_gate;
  logic      fast_rst;

  always_comb begin
    if (io_addr == IO_AW'(CMD_PORT))       sel = SEL_CMD;
    else if (io_addr == IO_AW'(DATA_PORT)) sel = SEL_DATA;
    else if (io_addr == IO_AW'(FAST_PORT)) sel = SEL_FAST;
    else                                   sel = SEL_NONE;
  end

  a20_kbc #(.BUSY_CYCLES(BUSY_CYCLES)) u_kbc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (io_wr && sel == SEL_CMD),
    .data_wr   (io_wr && sel == SEL_DATA),
    .wdata     (io_wdata),
    .busy      (kbc_busy),
    .outreg    (outport),
    .rst_pulse (kbc_rst)
  );

  a20_fastport u_fast (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (io_wr && sel == SEL_FAST),
    .wbits     (io_wdata[1:0]),
    .gate      (fast_gate),
    .rst_pulse (fast_rst)
  );

  assign a20_en        = outport[OUT_GATE_BIT] | fast_gate;
  assign cpu_reset_req = kbc_rst | fast_rst;

  a20_addr_mask #(.ADDR_W(ADDR_W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .open     (a20_en),
    .addr_in  (mem_addr_in),
    .addr_out (mem_addr_out)
  );

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      case (sel)
        SEL_CMD:  io_rdata[STAT_BUSY_BIT] = kbc_busy;
        SEL_DATA: io_rdata = outport;
        SEL_FAST: io_rdata[FAST_GATE_BIT] = fast_gate;
        default:  io_rdata = 8'h00;
      endcase
    end
  end

  assert_gate_follows_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fast_gate |-> a20_en);
  assert_gate_follows_outreg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outport[OUT_GATE_BIT] |-> a20_en);
  assert_idle_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == 8'h00));
endmodule

// File: tb/tb_a20_gate_ctrl.sv
module tb_a20_gate_ctrl;
  localparam int BUSY = 4;
  localparam logic [15:0] PCMD = 16'h0064, PDAT = 16'h0060, PFAST = 16'h0092;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [31:0] mem_addr_in = '0, mem_addr_out;
  logic        a20_en, cpu_reset_req;
  logic [7:0]  outport;

  int checks = 0, errors = 0;
  logic pulse_now;

  always #2.5 clk = ~clk;

  a20_gate_ctrl #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr_in(mem_addr_in),
    .mem_addr_out(mem_addr_out), .a20_en(a20_en), .cpu_reset_req(cpu_reset_req),
    .outport(outport)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; the write lands at the next rising edge, and
  // the task returns at the falling edge after it, where registers are updated.
  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    #0.5 pulse_now = cpu_reset_req;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    #0.5 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic wait_ready();
    logic [7:0] s;
    for (int i = 0; i < 100; i++) begin
      io_read(PCMD, s);
      if (!s[1]) break;
      @(negedge clk);
    end
  endtask

  task automatic check_mask(input string req, input logic gate_exp);
    mem_addr_in = 32'h0010_0000; #0.5;
    chk(req, mem_addr_out, gate_exp ? 32'h0010_0000 : 32'h0);
    mem_addr_in = 32'h3012_3456; #0.5;
    chk(req, mem_addr_out, gate_exp ? 32'h3012_3456 : 32'h3002_3456);
    mem_addr_in = 32'h000F_FFFF; #0.5;
    chk(req, mem_addr_out, 32'h000F_FFFF);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R1 gate", a20_en, 0);
    chk("R1 reset req", cpu_reset_req, 0);
    chk("R1 outport pins", outport, 8'h01);
    io_read(PDAT, d); chk("R1 outreg read", d, 8'h01);
    io_read(PCMD, d); chk("R1 status", d, 8'h00);
    io_read(PFAST, d); chk("R1 fast read", d, 8'h00);
    check_mask("R1/R10 closed mask", 1'b0);
    io_read(16'h0070, d); chk("R11 unmapped read", d, 8'h00);
    #0.5 chk("R11 idle rdata", io_rdata, 8'h00);
  endtask

  task automatic t_open_kbc();
    logic [7:0] d;
    int ones;
    wait_ready();
    io_write(PCMD, 8'hD1);
    ones = 0;
    for (int i = 0; i < BUSY + 3; i++) begin
      io_read(PCMD, d);
      if (d[1]) ones++;
      if (i == 0) chk("R2 other status bits", d & 8'hFD, 8'h00);
      @(negedge clk);
    end
    chk("R2 busy length", ones, BUSY);
    io_write(PDAT, 8'hFF);
    chk("R9 no pulse on bit0=1", pulse_now, 0);
    chk("R4 outport loaded", outport, 8'hFF);
    chk("R4 gate open", a20_en, 1);
    io_read(PDAT, d); chk("R4 data read", d, 8'hFF);
    check_mask("R10 open mask", 1'b1);
  endtask

  task automatic t_busy_drop();
    logic [7:0] d;
    wait_ready();
    io_write(PCMD, 8'hD1);
    io_write(PDAT, 8'h00);            // busy: must be dropped
    chk("R3 dropped data", outport, 8'hFF);
    chk("R3 no pulse", pulse_now, 0);
    wait_ready();
    io_write(PDAT, 8'hFC);            // pending D1 survived the drop
    chk("R3 pending kept", outport, 8'hFC);
    chk("R9 kbc pulse high", pulse_now, 1);
    @(negedge clk); #0.5;
    chk("R9 kbc pulse one cycle", cpu_reset_req, 0);
    chk("R4 gate closed", a20_en, 0);
    check_mask("R10 closed again", 1'b0);
    io_read(PCMD, d);
  endtask

  task automatic t_stray_data();
    wait_ready();
    io_write(PDAT, 8'h03);
    chk("R5 stray data ignored", outport, 8'hFC);
    wait_ready();
    io_write(PCMD, 8'hD1);
    wait_ready();
    io_write(PDAT, 8'h03);
    chk("R5 load", outport, 8'h03);
    wait_ready();
    io_write(PDAT, 8'h07);
    chk("R5 pending consumed", outport, 8'h03);
  endtask

  task automatic t_cancel();
    wait_ready();
    io_write(PCMD, 8'hD1);
    wait_ready();
    io_write(PCMD, 8'hAD);
    wait_ready();
    io_write(PDAT, 8'h01);
    chk("R6 cancelled", outport, 8'h03);
    wait_ready();
    io_write(PCMD, 8'hD1);
    wait_ready();
    io_write(PDAT, 8'h01);
    chk("R6 reload after cancel", outport, 8'h01);
    chk("R8 both closed", a20_en, 0);
  endtask

  task automatic t_fast();
    logic [7:0] d;
    io_write(PFAST, 8'h02);
    chk("R7/R8 fast opens", a20_en, 1);
    chk("R9 no fast pulse", pulse_now, 0);
    io_read(PFAST, d); chk("R7 fast read", d, 8'h02);
    check_mask("R10 fast open", 1'b1);
    io_write(PFAST, 8'h03);
    chk("R9 fast pulse high", pulse_now, 1);
    chk("R7 fast still open", a20_en, 1);
    @(negedge clk); #0.5;
    chk("R9 fast pulse one cycle", cpu_reset_req, 0);
    io_write(PFAST, 8'hFD);
    chk("R7 only bit1 stored", a20_en, 0);
    io_read(PFAST, d); chk("R7 fast read clear", d, 8'h00);
    wait_ready();
    io_write(PCMD, 8'hD1);
    wait_ready();
    io_write(PDAT, 8'h03);
    io_write(PFAST, 8'h02);
    chk("R8 both open", a20_en, 1);
    io_write(PFAST, 8'h00);
    chk("R8 kbc alone open", a20_en, 1);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_open_kbc();
    t_busy_drop();
    t_stray_data();
    t_cancel();
    t_fast();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule